// File: doc/BRIEF.md
# Staged Configuration Register Bank with Commit

This block holds sixteen byte-wide configuration registers on a CPU bus with a 24-bit address and 8-bit data. Software writes and reads back each register freely. These writes land only in a staged copy. The control flags that a downstream address mapper sees do not move until software issues an explicit commit. A commit is a write to the commit register with its top bit set. At that edge, bit 7 of every staged register is copied into its own bit of a 16-bit flag vector. After reset, two registers hold a set top bit, and that reset state has already been committed.

The same bus decoder also opens a byte-wide window onto a 32 KiB battery-backed SRAM. Eight banks each contribute a 4 KiB page to this window. The block drives the SRAM address, write data and strobes. The SRAM returns read data one clock after its read strobe. The block lines that data up with its own registered read path, so every read, from a register or from the SRAM, appears on the bus in the cycle after the read strobe.

Top module: `cfg_stage_bank`

## Requirements
- R1: The register bank answers only at offset 0x5000 (address bits 15:0) of banks 0x00 to 0x0F (address bits 23:16). The register index is bank bits 3:0. Offsets 0x4FFF, 0x5001 and 0x6000 in those banks, and offset 0x5000 in any other bank, do not reach a register.
- R2: A read strobe at a register address returns, in the following cycle, the full 8-bit value last written to that register's staged copy.
- R3: A register write with no commit changes only that register's staged copy. activeFlags keeps its value at every clock edge that does not carry a commit.
- R4: A write to register 0x0E whose data bit 7 is 1 is a commit. From the next cycle, activeFlags bit i equals bit 7 of staged register i for all sixteen i, and the value just written to register 0x0E is included.
- R5: A write to register 0x0E whose data bit 7 is 0 updates that staged register and leaves activeFlags unchanged.
- R6: After reset, all staged registers read 0x00, except registers 0x07 and 0x08, which read 0x80. activeFlags reads 16'h0180.
- R7: Banks 0x10 to 0x17 at offsets 0x5000 to 0x5FFF form the SRAM window. In the strobe cycle, sramAddr = (bank & 7) * 0x1000 + address bits 11:0. A write raises sramWe with sramWrData equal to the bus data. A read raises sramRe, and busRdData carries the SRAM byte in the following cycle.
- R8: A read strobe at an address outside the register bank and the SRAM window returns 0x00 in the following cycle. A write there raises no SRAM strobe and changes no staged register or flag. With no read strobe, busRdData is 0x00 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 24 | CPU address, bank in bits 23:16 |
| busWrData | input | 8 | CPU write data |
| busWr | input | 1 | Single-cycle write strobe |
| busRd | input | 1 | Single-cycle read strobe (ignored when busWr is high) |
| busRdData | output | 8 | Read data, valid the cycle after busRd |
| activeFlags | output | 16 | Committed control flags, one per register |
| sramAddr | output | 15 | SRAM byte address |
| sramWrData | output | 8 | SRAM write data |
| sramWe | output | 1 | SRAM write strobe |
| sramRe | output | 1 | SRAM read strobe |
| sramRdData | input | 8 | SRAM read data, one cycle after sramRe |

## Verification
The in-line assertions check on every cycle that the flags hold still at any edge without a commit, that a commit always leaves the commit flag itself set, that a staged write lands in the addressed register, and that an idle or missed read returns zero. Only the bench's scenarios can show the things that depend on the address map and on history. These are the exact decode boundaries across all 256 banks, the page arithmetic of the SRAM address, the reset defaults, and whether the flags after a commit match the staged top bits that accumulated over many earlier writes.

// File: rtl/cfgstage_pkg.sv
package cfgstage_pkg;
  localparam int REG_COUNT = 16;
  localparam int IDX_W     = $clog2(REG_COUNT);

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_REG  = 2'd1,
    SEL_SRAM = 2'd2
  } rdSel_e;

  typedef struct packed {
    logic             regWr;
    logic             regRd;
    logic             sramWr;
    logic             sramRd;
    logic             commit;
    logic [IDX_W-1:0] idx;
  } ctrlStrobe_t;
endpackage

// File: rtl/cfgstage_ctrl.sv
module cfgstage_ctrl
  import cfgstage_pkg::*;
#(
  parameter int          ADDR_W         = 24,
  parameter int          DATA_W         = 8,
  parameter int          SRAM_AW        = 15,
  parameter int          PAGE_BITS      = 12,
  parameter logic [15:0] REG_OFFSET     = 16'h5000,
  parameter logic [7:0]  SRAM_BANK_BASE = 8'h10,
  parameter int          COMMIT_IDX     = 14,
  parameter int          COMMIT_BIT     = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  input  logic               busWr,
  input  logic               busRd,
  output ctrlStrobe_t        strobe,
  output logic [SRAM_AW-1:0] sramAddr
);
  localparam int          BANK_SEL_W   = SRAM_AW - PAGE_BITS;
  localparam int          PAGE_TAG_W   = 16 - PAGE_BITS;
  localparam logic [7:0]  REG_BANK_END = 8'(REG_COUNT - 1);
  localparam logic [7:0]  SRAM_SPAN    = 8'(1 << BANK_SEL_W);
  localparam logic [PAGE_TAG_W-1:0] SRAM_PAGE = REG_OFFSET[15:PAGE_BITS];
  localparam logic [IDX_W-1:0]      CMT_IDX   = IDX_W'(COMMIT_IDX);

  logic [7:0]  bank;
  logic [15:0] offs;
  logic [7:0]  bankRel;
  logic        regHit;
  logic        sramHit;
  logic        rdReq;

  assign bank    = busAddr[ADDR_W-1:ADDR_W-8];
  assign offs    = busAddr[15:0];
  assign bankRel = bank - SRAM_BANK_BASE;
  assign regHit  = (bank <= REG_BANK_END) && (offs == REG_OFFSET);
  assign sramHit = (bankRel < SRAM_SPAN) && (offs[15:PAGE_BITS] == SRAM_PAGE);
  assign rdReq   = busRd && !busWr;

  always_comb begin
    strobe        = '0;
    strobe.idx    = bank[IDX_W-1:0];
    strobe.regWr  = busWr && regHit;
    strobe.regRd  = rdReq && regHit;
    strobe.sramWr = busWr && sramHit;
    strobe.sramRd = rdReq && sramHit;
    strobe.commit = strobe.regWr && (strobe.idx == CMT_IDX) && busWrData[COMMIT_BIT];
  end

  assign sramAddr = {bankRel[BANK_SEL_W-1:0], offs[PAGE_BITS-1:0]};

  // R4
  commit_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> (busWr && busWrData[COMMIT_BIT]));

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.regWr, strobe.regRd, strobe.sramWr, strobe.sramRd}));
endmodule

// File: rtl/cfgstage_dp.sv
module cfgstage_dp
  import cfgstage_pkg::*;
#(
  parameter int                    DATA_W          = 8,
  parameter int                    COMMIT_IDX      = 14,
  parameter int                    COMMIT_BIT      = 7,
  parameter logic [REG_COUNT-1:0]  RESET_HIGH_MASK = 16'h0180,
  parameter logic [7:0]            RESET_HIGH_VAL  = 8'h80
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [DATA_W-1:0]    sramRdData,
  output logic [DATA_W-1:0]    rdData,
  output logic [REG_COUNT-1:0] activeFlags
);
  logic [DATA_W-1:0]    stagedQ [REG_COUNT];
  logic [REG_COUNT-1:0] nextTopBits;
  logic [DATA_W-1:0]    regDataQ;
  rdSel_e               rdSelQ;

  function automatic logic [DATA_W-1:0] rstVal(int i);
    return RESET_HIGH_MASK[i] ? DATA_W'(RESET_HIGH_VAL) : '0;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) stagedQ[i] <= rstVal(i);
    end else if (strobe.regWr) begin
      stagedQ[strobe.idx] <= wrData;
    end
  end

  // Top bits as they stand after this cycle's write, so a commit sees its own data.
  for (genvar g = 0; g < REG_COUNT; g++) begin : gTop
    assign nextTopBits[g] = (strobe.regWr && strobe.idx == IDX_W'(g))
                          ? wrData[COMMIT_BIT] : stagedQ[g][COMMIT_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) activeFlags[i] <= rstVal(i)[COMMIT_BIT];
    end else if (strobe.commit) begin
      activeFlags <= nextTopBits;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdSelQ   <= SEL_NONE;
      regDataQ <= '0;
    end else begin
      rdSelQ   <= strobe.regRd ? SEL_REG : (strobe.sramRd ? SEL_SRAM : SEL_NONE);
      regDataQ <= strobe.regRd ? stagedQ[strobe.idx] : '0;
    end
  end

  always_comb begin
    unique case (rdSelQ)
      SEL_REG:  rdData = regDataQ;
      SEL_SRAM: rdData = sramRdData;
      default:  rdData = '0;
    endcase
  end

  // R3
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(activeFlags));

  // R4
  commit_self_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> activeFlags[COMMIT_IDX]);

  // R2
  staged_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.regWr |=> (stagedQ[$past(strobe.idx)] == $past(wrData)));

  // R8
  idle_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.regRd || strobe.sramRd) |=> (rdData == '0));
endmodule

// File: rtl/cfg_stage_bank.sv
module cfg_stage_bank
  import cfgstage_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 8,
  parameter int SRAM_AW = 15
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWrData,
  input  logic                 busWr,
  input  logic                 busRd,
  output logic [DATA_W-1:0]    busRdData,
  output logic [REG_COUNT-1:0] activeFlags,
  output logic [SRAM_AW-1:0]   sramAddr,
  output logic [DATA_W-1:0]    sramWrData,
  output logic                 sramWe,
  output logic                 sramRe,
  input  logic [DATA_W-1:0]    sramRdData
);
  ctrlStrobe_t strobe;

  cfgstage_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRAM_AW(SRAM_AW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busWr     (busWr),
    .busRd     (busRd),
    .strobe    (strobe),
    .sramAddr  (sramAddr)
  );

  cfgstage_dp #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrData      (busWrData),
    .sramRdData  (sramRdData),
    .rdData      (busRdData),
    .activeFlags (activeFlags)
  );

  assign sramWrData = busWrData;
  assign sramWe     = strobe.sramWr;
  assign sramRe     = strobe.sramRd;
endmodule

// File: tb/cfg_stage_bank_tb.sv
module cfg_stage_bank_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] busAddr = '0;
  logic [7:0]  busWrData = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  busRdData;
  logic [15:0] activeFlags;
  logic [14:0] sramAddr;
  logic [7:0]  sramWrData;
  logic        sramWe;
  logic        sramRe;
  logic [7:0]  sramRdData = '0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [7:0]  stagedModel [16];
  logic [15:0] flagsModel;
  logic [7:0]  dutMem [int];
  logic [7:0]  sramModel [int];

  always #10 clk = ~clk;

  cfg_stage_bank u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWr(busWr), .busRd(busRd), .busRdData(busRdData),
    .activeFlags(activeFlags), .sramAddr(sramAddr), .sramWrData(sramWrData),
    .sramWe(sramWe), .sramRe(sramRe), .sramRdData(sramRdData)
  );

  always @(posedge clk) begin
    if (sramWe) dutMem[int'(sramAddr)] = sramWrData;
    if (sramRe) sramRdData <= dutMem.exists(int'(sramAddr)) ? dutMem[int'(sramAddr)] : 8'h00;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [23:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(logic [23:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdData;
  endtask

  function automatic logic [15:0] topBits();
    logic [15:0] f;
    for (int i = 0; i < 16; i++) f[i] = stagedModel[i][7];
    return f;
  endfunction

  function automatic int sramIndex(logic [23:0] a);
    return int'(a[18:16]) * 4096 + int'(a[11:0]);
  endfunction

  function automatic logic [7:0] expRead(logic [23:0] a);
    if (a[23:16] <= 8'h0F && a[15:0] == 16'h5000) return stagedModel[a[19:16]];
    if (a[23:16] >= 8'h10 && a[23:16] <= 8'h17 && a[15:12] == 4'h5)
      return sramModel.exists(sramIndex(a)) ? sramModel[sramIndex(a)] : 8'h00;
    return 8'h00;
  endfunction

  task automatic regWrite(int idx, logic [7:0] d);
    busWrite({4'h0, 4'(idx), 16'h5000}, d);
    stagedModel[idx] = d;
    if (idx == 14 && d[7]) flagsModel = topBits();
  endtask

  task automatic readAllRegs(string req);
    logic [7:0] d;
    for (int i = 0; i < 16; i++) begin
      busRead({4'h0, 4'(i), 16'h5000}, d);
      chk(req, {24'h0, d}, {24'h0, stagedModel[i]});
    end
  endtask

  task automatic missWrite(logic [23:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    #1;
    chk("R8 miss write sramWe", {31'h0, sramWe}, 32'h0);
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic sramWriteChk(logic [23:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    #1;
    chk("R7 sramWe", {31'h0, sramWe}, 32'h1);
    chk("R7 sramAddr", {17'h0, sramAddr}, sramIndex(a));
    chk("R7 sramWrData", {24'h0, sramWrData}, {24'h0, d});
    @(negedge clk);
    busWr = 1'b0;
    sramModel[sramIndex(a)] = d;
  endtask

  initial begin : main
    logic [7:0] d;
    logic [15:0] offs [5];
    offs[0] = 16'h4FFF; offs[1] = 16'h5000; offs[2] = 16'h5001;
    offs[3] = 16'h5FFF; offs[4] = 16'h6000;
    for (int i = 0; i < 16; i++) stagedModel[i] = (i == 7 || i == 8) ? 8'h80 : 8'h00;
    flagsModel = 16'h0180;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R6 reset defaults
    chk("R6 flags after reset", {16'h0, activeFlags}, 32'h0180);
    chk("R8 idle read data", {24'h0, busRdData}, 32'h0);
    readAllRegs("R6 staged default");

    // R2 / R3 write and read back without commit
    for (int i = 0; i < 16; i++)
      if (i != 14) regWrite(i, 8'((i * 37 + 8'h5A) & 8'hFF));
    readAllRegs("R2 readback");
    chk("R3 flags unchanged", {16'h0, activeFlags}, {16'h0, flagsModel});

    // R5 commit register with bit 7 clear
    regWrite(14, 8'h7F);
    chk("R5 no commit", {16'h0, activeFlags}, {16'h0, flagsModel});
    busRead(24'h0E5000, d);
    chk("R5 staged value", {24'h0, d}, 32'h7F);

    // R4 commit
    regWrite(14, 8'h80);
    chk("R4 flags after commit", {16'h0, activeFlags}, {16'h0, flagsModel});

    // R3 flip all top bits, then R4 commit again
    for (int i = 0; i < 16; i++)
      if (i != 14) regWrite(i, stagedModel[i] ^ 8'h80);
    chk("R3 flags held", {16'h0, activeFlags}, {16'h0, flagsModel});
    regWrite(14, 8'hC3);
    chk("R4 second commit", {16'h0, activeFlags}, {16'h0, flagsModel});
    readAllRegs("R2 readback after commit");

    // R8 writes outside the decode do nothing
    for (int b = 0; b < 16; b++) begin
      missWrite({4'h0, 4'(b), 16'h4FFF}, 8'hFF);
      missWrite({4'h0, 4'(b), 16'h5001}, 8'hFF);
    end
    missWrite(24'h8E5000, 8'hFF);
    missWrite(24'h1E5000, 8'hFF);
    missWrite(24'h185000, 8'hFF);
    chk("R8 flags after miss writes", {16'h0, activeFlags}, {16'h0, flagsModel});
    readAllRegs("R8 staged after miss writes");

    // R7 SRAM window writes
    for (int b = 8'h10; b <= 8'h17; b++) begin
      sramWriteChk({8'(b), 16'h5000}, 8'(b * 3 + 1));
      sramWriteChk({8'(b), 16'h5FFF}, 8'(b * 5 + 2));
      sramWriteChk({8'(b), 16'h5ABC}, 8'(b ^ 8'hA5));
    end

    // R1 / R7 / R8 read sweep over every bank
    for (int b = 0; b < 256; b++)
      for (int k = 0; k < 5; k++) begin
        logic [23:0] a;
        a = {8'(b), offs[k]};
        busRead(a, d);
        chk("R1 R7 R8 read sweep", {24'h0, d}, {24'h0, expRead(a)});
      end
    busRead(24'h135ABC, d);
    chk("R7 page read", {24'h0, d}, {24'h0, 8'(8'h13 ^ 8'hA5)});

    // R4 final commit with all flags cleared except commit bit
    for (int i = 0; i < 16; i++)
      if (i != 14) regWrite(i, 8'h01);
    regWrite(14, 8'h80);
    chk("R4 commit to single flag", {16'h0, activeFlags}, 32'h4000);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule